// File: doc/BRIEF.md
# Audio Codec Control Register File

This block is the 16-bit indexed control store of a stereo audio codec. The link interface hands it one command at a time: a write (index plus data) or a read request (index). The block keeps the volume and mute settings, record source and gain, general-purpose and 3D controls, power-down requests, extended audio control, the two sample-rate registers and the S/PDIF channel-status word. It returns read data one cycle after a read request, and it drives the decoded fields that the converter and mixer datapath need.

Each register applies its own write rules. Reserved bits are dropped. The two main volume registers saturate a channel when its optional sixth bit is set. The two rate registers store the nearest supported sample rate. The power register merges live ready flags from the analog side into its read value. A write of any value to index 00h puts every register back to its default, and so does the cold reset.

Top module: `codec_regfile`

## Requirements
- R1: Both a write of any data to index 00h and the cold reset `rst_ni` return every register to its default. After a write, the registers read their defaults from the next cycle on.
- R2: A read of index 00h returns the fixed capability code 16'h6A90.
- R3: A read of any odd index returns 0. A read of any index not listed in R6, R9, R10 or R11 also returns 0. A write to an odd or unlisted index changes no register.
- R4: `rvalid_o` is 1 in exactly the cycle after a cycle with `rd_i`=1, and `rdata_o` carries the read value at that time. When a read and a write arrive in the same cycle, the read returns the value held before the write.
- R5: On indices 02h and 04h, a write with bit 13 set stores 5'h1F in bits 12:8, and a write with bit 5 set stores 5'h1F in bits 4:0. Bits 13 and 5 always read back 0.
- R6: Register defaults and writable masks: 02h/04h 8000/9F1F; 06h 8000/801F; 0Ah 0000/801E; 0Ch 8008/801F; 0Eh 8008/805F; 10h, 12h, 14h, 16h, 18h 8808/9F1F; 1Ah 0000/0707; 1Ch 8000/8F0F; 20h 0000/2380; 22h 0000/000C; 3Ah 2000/BFFE. Bits outside the mask read 0.
- R7: Indices 2Ch (output rate) and 32h (input rate) default to BB80h (48000). A write stores the nearest of 8000, 11025, 12000, 16000, 22050, 24000, 32000, 44100 and 48000. On an exact tie the lower rate is stored, and values above 48000 store 48000.
- R8: When bit 0 (variable-rate enable) of index 2Ah is 0, `dac_rate_o` and `adc_rate_o` both show BB80h whatever the rate registers hold. When that bit is 1, they show the stored values of 2Ch and 32h.
- R9: Index 26h: bits 15:8 are read/write, default 0, and drive `pwr_ctl_o`. Bits 7:4 read 0. Bits 3:0 read `ready_i` (bit 0 ADC, bit 1 DAC, bit 2 mixer, bit 3 reference) as it was in the cycle of the request. Writes never change bits 7:0.
- R10: Index 2Ah defaults to 0030h and has writable mask 0035h: bit 0 enables variable rate, bit 2 enables S/PDIF (`spdif_en_o`), and bits 5:4 assign the S/PDIF slot.
- R11: `spdif_strap_i` is sampled in the first clock after reset is released. If it was 1, only bit 0 of index 2Ah can be written, and bits 15:1 read 0.
- R12: Index 1Ah bits 10:8 drive `rec_sel_l_o` and bits 2:0 drive `rec_sel_r_o`. The codes are 0 mic, 1 CD, 2 video, 3 aux, 4 line, 5 stereo mix, 6 mono mix, 7 phone.
- R13: Index 02h drives `master_mute_o` (bit 15), `master_l_o` (bits 12:8) and `master_r_o` (bits 4:0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous cold reset |
| spdif_strap_i | input | 1 | Level of the S/PDIF pin, sampled after reset |
| ready_i | input | 4 | Ready flags {reference, mixer, DAC, ADC} |
| wr_i | input | 1 | Write request |
| rd_i | input | 1 | Read request |
| idx_i | input | 7 | Register byte index |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data |
| rvalid_o | output | 1 | Read data valid |
| master_mute_o | output | 1 | Master mute |
| master_l_o | output | 5 | Master left attenuation |
| master_r_o | output | 5 | Master right attenuation |
| rec_sel_l_o | output | 3 | Left record source |
| rec_sel_r_o | output | 3 | Right record source |
| pwr_ctl_o | output | 8 | Power-down requests |
| vra_en_o | output | 1 | Variable-rate enable |
| spdif_en_o | output | 1 | S/PDIF enable |
| dac_rate_o | output | 16 | Effective output sample rate |
| adc_rate_o | output | 16 | Effective input sample rate |

## Verification
The hardest state to reach is the strapped configuration. The strap can only be set by a fresh cold reset with `spdif_strap_i` held high through the first clock after release. The bench therefore runs a second reset phase with the pin high and then writes all ones to 2Ah. Rate snapping is tested at the exact midpoints between neighbouring rates and one code above them, and a read is issued in the same cycle as a write to the same index.

// File: rtl/crf_pkg.sv
package crf_pkg;
  localparam int unsigned DW      = 16;
  localparam int unsigned AW      = 7;
  localparam int unsigned N_PLAIN = 16;
  localparam int unsigned N_RATES = 9;

  localparam logic [AW-1:0] IDX_CAPS = 7'h00;
  localparam logic [AW-1:0] IDX_PWR  = 7'h26;
  localparam logic [AW-1:0] IDX_EXT  = 7'h2A;
  localparam logic [AW-1:0] IDX_OUTR = 7'h2C;
  localparam logic [AW-1:0] IDX_INR  = 7'h32;

  localparam logic [DW-1:0] CAPS_CODE   = 16'h6A90;
  localparam logic [DW-1:0] RATE_DFLT   = 16'hBB80;
  localparam logic [DW-1:0] EXT_DFLT    = 16'h0030;
  localparam logic [DW-1:0] EXT_MASK    = 16'h0035;
  localparam logic [DW-1:0] EXT_MASK_ST = 16'h0001;

  typedef struct packed {
    logic [AW-1:0] idx;
    logic [DW-1:0] mask;
    logic [DW-1:0] dflt;
    logic          sat;
  } reg_desc_t;

  localparam reg_desc_t PLAIN_TAB [N_PLAIN] = '{
    '{7'h02, 16'h9F1F, 16'h8000, 1'b1},
    '{7'h04, 16'h9F1F, 16'h8000, 1'b1},
    '{7'h06, 16'h801F, 16'h8000, 1'b0},
    '{7'h0A, 16'h801E, 16'h0000, 1'b0},
    '{7'h0C, 16'h801F, 16'h8008, 1'b0},
    '{7'h0E, 16'h805F, 16'h8008, 1'b0},
    '{7'h10, 16'h9F1F, 16'h8808, 1'b0},
    '{7'h12, 16'h9F1F, 16'h8808, 1'b0},
    '{7'h14, 16'h9F1F, 16'h8808, 1'b0},
    '{7'h16, 16'h9F1F, 16'h8808, 1'b0},
    '{7'h18, 16'h9F1F, 16'h8808, 1'b0},
    '{7'h1A, 16'h0707, 16'h0000, 1'b0},
    '{7'h1C, 16'h8F0F, 16'h8000, 1'b0},
    '{7'h20, 16'h2380, 16'h0000, 1'b0},
    '{7'h22, 16'h000C, 16'h0000, 1'b0},
    '{7'h3A, 16'hBFFE, 16'h2000, 1'b0}
  };

  localparam int unsigned SLOT_MASTER = 0;
  localparam int unsigned SLOT_RECSEL = 11;

  function automatic logic [DW-1:0] rate_at(int unsigned k);
    case (k)
      0:       return 16'd8000;
      1:       return 16'd11025;
      2:       return 16'd12000;
      3:       return 16'd16000;
      4:       return 16'd22050;
      5:       return 16'd24000;
      6:       return 16'd32000;
      7:       return 16'd44100;
      default: return 16'd48000;
    endcase
  endfunction

  function automatic logic [DW:0] rate_dist(logic [DW-1:0] a, logic [DW-1:0] b);
    return (a >= b) ? {1'b0, a - b} : {1'b0, b - a};
  endfunction

  // ascending table + strict compare: ties keep the lower rate
  function automatic logic [DW-1:0] snap_rate(logic [DW-1:0] w);
    logic [DW-1:0] best;
    logic [DW:0]   bd;
    logic [DW:0]   d;
    best = rate_at(0);
    bd   = rate_dist(w, best);
    for (int unsigned k = 1; k < N_RATES; k++) begin
      d = rate_dist(w, rate_at(k));
      if (d < bd) begin
        bd   = d;
        best = rate_at(k);
      end
    end
    return best;
  endfunction

  function automatic logic [DW-1:0] vol_sat(logic [DW-1:0] w);
    logic [DW-1:0] r;
    r = w;
    if (w[13]) r[12:8] = 5'h1F;
    if (w[5])  r[4:0]  = 5'h1F;
    return r;
  endfunction
endpackage

// File: rtl/crf_plain_reg.sv
module crf_plain_reg
  import crf_pkg::*;
#(
  parameter logic [DW-1:0] MASK = '1,
  parameter logic [DW-1:0] DFLT = '0,
  parameter bit            SAT  = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] q_o
);
  logic [DW-1:0] val_q;
  logic [DW-1:0] wr_val;

  generate
    if (SAT) begin : g_sat
      assign wr_val = vol_sat(wdata_i) & MASK;
    end else begin : g_plain
      assign wr_val = wdata_i & MASK;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    val_q <= DFLT;
    else if (clr_i) val_q <= DFLT;
    else if (we_i)  val_q <= wr_val;
  end

  assign q_o = val_q;
endmodule

// File: rtl/crf_rate_reg.sv
module crf_rate_reg
  import crf_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          vra_i,
  output logic [DW-1:0] q_o,
  output logic [DW-1:0] eff_o
);
  logic [DW-1:0] val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    val_q <= RATE_DFLT;
    else if (clr_i) val_q <= RATE_DFLT;
    else if (we_i)  val_q <= snap_rate(wdata_i);
  end

  assign q_o   = val_q;
  assign eff_o = vra_i ? val_q : RATE_DFLT;
endmodule

// File: rtl/crf_ext_reg.sv
module crf_ext_reg
  import crf_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          strap_i,
  output logic [DW-1:0] q_o
);
  logic [DW-1:0] val_q;
  logic [DW-1:0] mask;
  logic          strap_q;
  logic          seen_q;

  assign mask = strap_q ? EXT_MASK_ST : EXT_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q   <= EXT_DFLT;
      strap_q <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      if (!seen_q) begin
        strap_q <= strap_i;
        seen_q  <= 1'b1;
      end
      if (clr_i)     val_q <= EXT_DFLT;
      else if (we_i) val_q <= wdata_i & mask;
    end
  end

  assign q_o = val_q & mask;
endmodule

// File: rtl/codec_regfile.sv
module codec_regfile
  import crf_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          spdif_strap_i,
  input  logic [3:0]    ready_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [AW-1:0] idx_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o,
  output logic          master_mute_o,
  output logic [4:0]    master_l_o,
  output logic [4:0]    master_r_o,
  output logic [2:0]    rec_sel_l_o,
  output logic [2:0]    rec_sel_r_o,
  output logic [7:0]    pwr_ctl_o,
  output logic          vra_en_o,
  output logic          spdif_en_o,
  output logic [DW-1:0] dac_rate_o,
  output logic [DW-1:0] adc_rate_o
);
  logic          soft_clr;
  logic [DW-1:0] plain_q [N_PLAIN];
  logic [DW-1:0] ext_q;
  logic [DW-1:0] outr_q;
  logic [DW-1:0] inr_q;
  logic [7:0]    pwr_q;
  logic [DW-1:0] rd_val;
  logic [DW-1:0] rdata_q;
  logic          rvalid_q;

  assign soft_clr = wr_i && (idx_i == IDX_CAPS);

  generate
    for (genvar g = 0; g < N_PLAIN; g++) begin : g_plain
      crf_plain_reg #(
        .MASK (PLAIN_TAB[g].mask),
        .DFLT (PLAIN_TAB[g].dflt),
        .SAT  (PLAIN_TAB[g].sat)
      ) u_reg (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (soft_clr),
        .we_i    (wr_i && (idx_i == PLAIN_TAB[g].idx)),
        .wdata_i (wdata_i),
        .q_o     (plain_q[g])
      );
    end
  endgenerate

  crf_ext_reg u_ext (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (soft_clr),
    .we_i    (wr_i && (idx_i == IDX_EXT)),
    .wdata_i (wdata_i),
    .strap_i (spdif_strap_i),
    .q_o     (ext_q)
  );

  crf_rate_reg u_outr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (soft_clr),
    .we_i    (wr_i && (idx_i == IDX_OUTR)),
    .wdata_i (wdata_i),
    .vra_i   (ext_q[0]),
    .q_o     (outr_q),
    .eff_o   (dac_rate_o)
  );

  crf_rate_reg u_inr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (soft_clr),
    .we_i    (wr_i && (idx_i == IDX_INR)),
    .wdata_i (wdata_i),
    .vra_i   (ext_q[0]),
    .q_o     (inr_q),
    .eff_o   (adc_rate_o)
  );

  // power-down requests: upper byte only, status comes from ready_i
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            pwr_q <= '0;
    else if (soft_clr)                      pwr_q <= '0;
    else if (wr_i && (idx_i == IDX_PWR))    pwr_q <= wdata_i[15:8];
  end

  always_comb begin
    rd_val = '0;
    if (idx_i == IDX_CAPS) rd_val = CAPS_CODE;
    if (idx_i == IDX_PWR)  rd_val = {pwr_q, 4'b0, ready_i};
    if (idx_i == IDX_EXT)  rd_val = ext_q;
    if (idx_i == IDX_OUTR) rd_val = outr_q;
    if (idx_i == IDX_INR)  rd_val = inr_q;
    for (int k = 0; k < N_PLAIN; k++)
      if (idx_i == PLAIN_TAB[k].idx) rd_val = plain_q[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_i;
      if (rd_i) rdata_q <= rd_val;
    end
  end

  assign rdata_o       = rdata_q;
  assign rvalid_o      = rvalid_q;
  assign master_mute_o = plain_q[SLOT_MASTER][15];
  assign master_l_o    = plain_q[SLOT_MASTER][12:8];
  assign master_r_o    = plain_q[SLOT_MASTER][4:0];
  assign rec_sel_l_o   = plain_q[SLOT_RECSEL][10:8];
  assign rec_sel_r_o   = plain_q[SLOT_RECSEL][2:0];
  assign pwr_ctl_o     = pwr_q;
  assign vra_en_o      = ext_q[0];
  assign spdif_en_o    = ext_q[2];
endmodule

// File: rtl/crf_chk.sv
module crf_chk
  import crf_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic [3:0]    ready_i,
  input logic          wr_i,
  input logic          rd_i,
  input logic [AW-1:0] idx_i,
  input logic [DW-1:0] wdata_i,
  input logic [DW-1:0] rdata_o,
  input logic          rvalid_o,
  input logic          master_mute_o,
  input logic [4:0]    master_l_o,
  input logic [4:0]    master_r_o,
  input logic [2:0]    rec_sel_l_o,
  input logic [7:0]    pwr_ctl_o,
  input logic          vra_en_o,
  input logic [DW-1:0] dac_rate_o,
  input logic [DW-1:0] adc_rate_o
);
  function automatic logic is_rate(logic [DW-1:0] v);
    logic hit;
    hit = 1'b0;
    for (int unsigned k = 0; k < N_RATES; k++)
      if (v == rate_at(k)) hit = 1'b1;
    return hit;
  endfunction

  // R1
  soft_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx_i == IDX_CAPS) |=> (master_mute_o && master_l_o == 5'h0 &&
      master_r_o == 5'h0 && rec_sel_l_o == 3'h0 && pwr_ctl_o == 8'h0 && !vra_en_o));

  // R2
  caps_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && idx_i == IDX_CAPS) |=> (rdata_o == 16'h6A90));

  // R3
  odd_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && idx_i[0]) |=> (rdata_o == 16'h0000));

  // R4
  rvalid_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rvalid_o);

  // R4
  rvalid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> !rvalid_o);

  // R5
  master_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx_i == 7'h02 && wdata_i[13]) |=> (master_l_o == 5'h1F));

  // R7
  rate_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_rate(dac_rate_o) && is_rate(adc_rate_o)));

  // R8
  fixed_rate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vra_en_o |-> (dac_rate_o == 16'hBB80 && adc_rate_o == 16'hBB80));

  // R9
  ready_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && idx_i == IDX_PWR) |=> (rdata_o[3:0] == $past(ready_i) && rdata_o[7:4] == 4'h0));
endmodule

bind codec_regfile crf_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ready_i       (ready_i),
  .wr_i          (wr_i),
  .rd_i          (rd_i),
  .idx_i         (idx_i),
  .wdata_i       (wdata_i),
  .rdata_o       (rdata_o),
  .rvalid_o      (rvalid_o),
  .master_mute_o (master_mute_o),
  .master_l_o    (master_l_o),
  .master_r_o    (master_r_o),
  .rec_sel_l_o   (rec_sel_l_o),
  .pwr_ctl_o     (pwr_ctl_o),
  .vra_en_o      (vra_en_o),
  .dac_rate_o    (dac_rate_o),
  .adc_rate_o    (adc_rate_o)
);

// File: tb/codec_regfile_tb.sv
`timescale 1ns/1ps
module codec_regfile_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        spdif_strap_i = 1'b0;
  logic [3:0]  ready_i = 4'h0;
  logic        wr_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [6:0]  idx_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        rvalid_o;
  logic        master_mute_o;
  logic [4:0]  master_l_o, master_r_o;
  logic [2:0]  rec_sel_l_o, rec_sel_r_o;
  logic [7:0]  pwr_ctl_o;
  logic        vra_en_o, spdif_en_o;
  logic [15:0] dac_rate_o, adc_rate_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit cmp_on = 0;

  logic [15:0] mdl [64];
  bit strap_m = 0;

  always #4 clk_i = ~clk_i;

  codec_regfile u_dut (.*);

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  function automatic logic [15:0] m_def(int s);
    case (s * 2)
      'h02, 'h04, 'h06, 'h1C: return 16'h8000;
      'h0C, 'h0E:             return 16'h8008;
      'h10, 'h12, 'h14, 'h16, 'h18: return 16'h8808;
      'h2A:                   return 16'h0030;
      'h2C, 'h32:             return 16'hBB80;
      'h3A:                   return 16'h2000;
      default:                return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] m_mask(int s);
    case (s * 2)
      'h02, 'h04, 'h10, 'h12, 'h14, 'h16, 'h18: return 16'h9F1F;
      'h06, 'h0C: return 16'h801F;
      'h0A: return 16'h801E;
      'h0E: return 16'h805F;
      'h1A: return 16'h0707;
      'h1C: return 16'h8F0F;
      'h20: return 16'h2380;
      'h22: return 16'h000C;
      'h26: return 16'hFF00;
      'h2A: return strap_m ? 16'h0001 : 16'h0035;
      'h3A: return 16'hBFFE;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] m_snap(logic [15:0] w);
    if (w <= 16'd9512)  return 16'd8000;
    if (w <= 16'd11512) return 16'd11025;
    if (w <= 16'd14000) return 16'd12000;
    if (w <= 16'd19025) return 16'd16000;
    if (w <= 16'd23025) return 16'd22050;
    if (w <= 16'd28000) return 16'd24000;
    if (w <= 16'd38050) return 16'd32000;
    if (w <= 16'd46050) return 16'd44100;
    return 16'd48000;
  endfunction

  task automatic m_reset();
    for (int s = 0; s < 64; s++) mdl[s] = m_def(s);
  endtask

  task automatic m_write(logic [6:0] idx, logic [15:0] w);
    int s;
    s = idx[6:1];
    if (idx[0]) return;
    if (idx == 7'h00) begin m_reset(); return; end
    if (idx == 7'h2C || idx == 7'h32) begin mdl[s] = m_snap(w); return; end
    if (idx == 7'h02 || idx == 7'h04) begin
      if (w[13]) w[12:8] = 5'h1F;
      if (w[5])  w[4:0]  = 5'h1F;
    end
    mdl[s] = w & m_mask(s);
  endtask

  function automatic logic [15:0] m_read(logic [6:0] idx);
    int s;
    s = idx[6:1];
    if (idx[0]) return 16'h0;
    if (idx == 7'h00) return 16'h6A90;
    if (idx == 7'h26) return mdl[s] | {12'h0, ready_i};
    if (idx == 7'h2A) return mdl[s] & m_mask(s);
    return mdl[s];
  endfunction

  // per-clock comparison of decoded outputs
  always @(negedge clk_i) begin
    if (cmp_on && rst_ni) begin
      logic vra;
      vra = m_read(7'h2A) & 16'h1;
      chk("R13 master", {master_mute_o, master_l_o, master_r_o},
          {mdl[1][15], mdl[1][12:8], mdl[1][4:0]});
      chk("R12 recsel", {rec_sel_l_o, rec_sel_r_o}, {mdl[13][10:8], mdl[13][2:0]});
      chk("R9 pwr_ctl", pwr_ctl_o, mdl[19][15:8]);
      chk("R10 enables", {vra_en_o, spdif_en_o}, {vra, m_read(7'h2A)[2]});
      chk("R8 dac_rate", dac_rate_o, vra ? mdl[22] : 16'hBB80);
      chk("R8 adc_rate", adc_rate_o, vra ? mdl[25] : 16'hBB80);
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic do_reset(bit strap);
    cmp_on = 0;
    @(negedge clk_i);
    spdif_strap_i = strap;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    strap_m = strap;
    m_reset();
    repeat (2) @(negedge clk_i);
    cmp_on = 1;
  endtask

  task automatic do_wr(logic [6:0] idx, logic [15:0] w);
    wr_i = 1'b1; idx_i = idx; wdata_i = w;
    @(posedge clk_i); #1;
    m_write(idx, w);
    wr_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic do_rd(string req, logic [6:0] idx);
    logic [15:0] exp;
    rd_i = 1'b1; idx_i = idx;
    exp = m_read(idx);
    @(posedge clk_i); #1;
    rd_i = 1'b0;
    @(negedge clk_i);
    chk(req, rdata_o, exp);
    chk("R4 rvalid", {15'h0, rvalid_o}, 16'h1);
  endtask

  task automatic do_rdwr(logic [6:0] idx, logic [15:0] w);
    logic [15:0] exp;
    rd_i = 1'b1; wr_i = 1'b1; idx_i = idx; wdata_i = w;
    exp = m_read(idx);
    @(posedge clk_i); #1;
    m_write(idx, w);
    rd_i = 1'b0; wr_i = 1'b0;
    @(negedge clk_i);
    chk("R4 read-before-write", rdata_o, exp);
  endtask

  task automatic rd_all(string req);
    for (int i = 0; i < 128; i++) do_rd(req, 7'(i));
  endtask

  initial begin
    logic [15:0] rates [10];
    logic [15:0] pat;
    rates = '{16'd0, 16'd9512, 16'd9513, 16'd14000, 16'd14001,
              16'd46050, 16'd46051, 16'd65535, 16'd44100, 16'd11513};

    do_reset(1'b0);
    // R1 R6 reset state, R2 caps, R3 odd and unlisted
    rd_all("R6 cold defaults");
    do_rd("R2 caps code", 7'h00);
    @(negedge clk_i);
    chk("R4 rvalid idle", {15'h0, rvalid_o}, 16'h0);

    // R5 saturation on master and headphone
    do_wr(7'h02, 16'h2A2A);
    do_rd("R5 master sat", 7'h02);
    do_wr(7'h04, 16'h2005);
    do_rd("R5 hp sat left", 7'h04);
    do_wr(7'h04, 16'h0720);
    do_rd("R5 hp sat right", 7'h04);

    // R6 masks with all-ones and patterns on every even index
    for (int i = 2; i < 128; i += 2) begin
      if (i == 'h2A) continue;
      do_wr(7'(i), 16'hFFFF);
    end
    rd_all("R6 ones masked");
    pat = 16'hA5C3;
    for (int i = 2; i < 128; i += 2) begin
      pat = {pat[14:0], pat[15] ^ pat[13] ^ pat[12] ^ pat[10]};
      if (i != 'h2A) do_wr(7'(i), pat);
    end
    rd_all("R6 pattern masked");

    // R3 odd writes ignored
    do_wr(7'h03, 16'h0000);
    do_wr(7'h1B, 16'h0000);
    do_rd("R3 odd write no effect", 7'h02);
    do_rd("R3 odd write no effect", 7'h1A);

    // R12 record select codes
    do_wr(7'h1A, 16'h0705);
    do_wr(7'h1A, 16'h0306);

    // R7 rate snapping incl. ties and out of range
    foreach (rates[k]) begin
      do_wr(7'h2C, rates[k]);
      do_rd("R7 out rate snap", 7'h2C);
      do_wr(7'h32, ~rates[k]);
      do_rd("R7 in rate snap", 7'h32);
    end

    // R8 VRA enable switches effective rates, R10 enables
    do_wr(7'h2C, 16'd22050);
    do_wr(7'h2A, 16'h0001);
    do_wr(7'h2A, 16'hFFFF);
    do_rd("R10 ext all ones", 7'h2A);
    do_wr(7'h2A, 16'h0004);
    do_rd("R10 ext spdif only", 7'h2A);

    // R9 power register with live ready flags
    do_wr(7'h26, 16'hFFFF);
    ready_i = 4'hA;
    do_rd("R9 pwr ready", 7'h26);
    ready_i = 4'h5;
    do_wr(7'h26, 16'h3C0F);
    do_rd("R9 pwr ready", 7'h26);

    // R4 read and write same cycle
    do_rdwr(7'h10, 16'h1234);
    do_rd("R4 write landed", 7'h10);

    // R1 soft reset by write to 00h
    do_wr(7'h00, 16'h1234);
    rd_all("R1 soft reset defaults");

    // R11 strapped configuration after a fresh reset
    do_reset(1'b1);
    do_rd("R11 strap ext default", 7'h2A);
    do_wr(7'h2A, 16'hFFFF);
    do_rd("R11 strap ext write", 7'h2A);
    do_wr(7'h2C, 16'd32000);
    do_rd("R11 rate reg", 7'h2C);
    rd_all("R11 strap sweep");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule